// File: doc/BRIEF.md
# Frame Pointer Mailbox Pair

This block lets a local processor and several remote bus masters pass message frames by reference. It holds two circular queues of pointer-sized words. The *free* queue lists empty frames. The *post* queue lists filled frames that are waiting to be handled. Each queue is reached through a single mapped location. Writing that location appends a word. Reading it removes and returns the oldest word in the same access, so two readers can never obtain the same pointer.

A remote producer reads the free location to claim an empty frame and fills the frame in memory elsewhere. It then writes the pointer to the post location. The local consumer reads the post location, handles the frame and hands the pointer back by writing the free location. Each direction is allowed only on its proper side: remote masters take free frames and post them, and the local side takes posted frames and returns them. All requesters share one access port per cycle and are ordered by a fixed priority. A synchronous initialize input empties both queues and clears the sticky flags. The frame memory and the data movement are not part of this block.

Top module: `mq_pair`

## Requirements
- R1: After reset both levels are 0, `free_overflow`, `post_overflow` and `access_error` are 0, and `rsp_valid` is all zero.
- R2: With `req_qsel`=0 (free queue), a write from the local side (`req_remote`=0) appends the word and a read from the remote side (`req_remote`=1) returns and removes the oldest word. Order is first-in first-out, including after the circular pointers wrap.
- R3: With `req_qsel`=1 (post queue), a write from the remote side appends the word and a read from the local side returns and removes the oldest word, in first-in first-out order.
- R4: A permitted read of an empty queue returns 0xFFFFFFFF and leaves that queue's level unchanged.
- R5: A permitted write to a queue holding DEPTH words is dropped and leaves the queue unchanged. It also sets that queue's sticky overflow flag, which stays set until initialization.
- R6: An access from the wrong side changes no queue. A read from the wrong side returns 0. Both reads and writes from the wrong side set the sticky `access_error` flag.
- R7: In each cycle at most one requester is granted, namely the lowest-numbered one with `req_valid` set. Only that requester's access takes effect.
- R8: The response follows one cycle after the grant. `rsp_valid` is then one-hot on the granted requester, and `rsp_data` carries the read result, or 0 for a write.
- R9: While `init` is high, no grant is issued. One cycle of `init` leaves both levels at 0 and all three flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init | input | 1 | Synchronous initialize: empty both queues, clear flags |
| req_valid | input | N_REQ | Per-requester access request |
| req_write | input | N_REQ | 1 = write (append), 0 = read (remove) |
| req_qsel | input | N_REQ | 0 = free queue, 1 = post queue |
| req_remote | input | N_REQ | 1 = requester is a remote master, 0 = local processor |
| req_wdata | input | N_REQ*W | Write words, requester i in bits [i*W +: W] |
| gnt | output | N_REQ | One-hot grant, same cycle as the request |
| rsp_valid | output | N_REQ | One-hot response strobe, one cycle after the grant |
| rsp_data | output | W | Read result, empty marker, or 0 |
| free_level | output | $clog2(DEPTH+1) | Words held in the free queue |
| post_level | output | $clog2(DEPTH+1) | Words held in the post queue |
| free_overflow | output | 1 | Sticky: a write to the full free queue was dropped |
| post_overflow | output | 1 | Sticky: a write to the full post queue was dropped |
| access_error | output | 1 | Sticky: an access came from the wrong side |

## Verification
A corrupted read or write pointer appears as a wrong pointer on `rsp_data` one cycle after the next permitted read of that queue. It can look like a duplicated or skipped frame. Such faults often surface only after the pointers wrap, so the checking keeps each queue cycling well past DEPTH entries. A wrong occupancy count shows on the level outputs at the next edge. It also shows at the boundaries as an empty marker returned too early, or as an overflow flag raised too early or too late. A fault in the side-permission decode shows in the cycle after the offending access: a queue level moves when it should not, or `access_error` stays low.

// File: rtl/mq_pkg.sv
package mq_pkg;

  typedef enum logic {
    Q_FREE = 1'b0,
    Q_POST = 1'b1
  } qsel_e;

  // Permission rule: free queue is filled locally and drained remotely,
  // post queue is filled remotely and drained locally.
  function automatic logic side_ok(logic qsel, logic wr, logic remote);
    return qsel ^ wr ^ remote;
  endfunction

  // Circular pointer advance.
  function automatic logic [31:0] wrap_inc(logic [31:0] p, logic [31:0] depth);
    return (p == depth - 32'd1) ? 32'd0 : p + 32'd1;
  endfunction

endpackage

// File: rtl/mq_ring.sv
module mq_ring #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               wdata,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full,
  output logic                       empty
);
  import mq_pkg::*;

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else if (clear) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= AW'(wrap_inc(32'(wr_ptr), 32'(DEPTH)));
      if (pop)  rd_ptr <= AW'(wrap_inc(32'(rd_ptr), 32'(DEPTH)));
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  assign head  = mem[rd_ptr];
  assign level = cnt;
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

endmodule

// File: rtl/mq_prio_arb.sv
module mq_prio_arb #(
  parameter int N = 3
) (
  input  logic         en,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic taken;

  always_comb begin
    gnt   = '0;
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (en && req[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/mq_gate.sv
module mq_gate #(
  parameter int W = 32
) (
  input  logic         hit,
  input  logic         wr,
  input  logic         qsel,
  input  logic         remote,
  input  logic [1:0]   full,
  input  logic [1:0]   empty,
  input  logic [W-1:0] head_free,
  input  logic [W-1:0] head_post,
  output logic [1:0]   push,
  output logic [1:0]   pop,
  output logic [1:0]   drop,
  output logic         bad,
  output logic         mark,
  output logic [W-1:0] rdata
);
  import mq_pkg::*;

  logic         ok;
  logic [W-1:0] head_sel;

  assign ok       = side_ok(qsel, wr, remote);
  assign head_sel = (qsel == Q_POST) ? head_post : head_free;

  always_comb begin
    push  = '0;
    pop   = '0;
    drop  = '0;
    bad   = 1'b0;
    mark  = 1'b0;
    rdata = '0;
    if (hit) begin
      if (!ok) begin
        bad = 1'b1;
      end else if (wr) begin
        if (full[qsel]) drop[qsel] = 1'b1;
        else            push[qsel] = 1'b1;
      end else if (empty[qsel]) begin
        mark  = 1'b1;
        rdata = '1;
      end else begin
        pop[qsel] = 1'b1;
        rdata     = head_sel;
      end
    end
  end

endmodule

// File: rtl/mq_pair.sv
module mq_pair #(
  parameter int N_REQ = 3,
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       init,
  input  logic [N_REQ-1:0]           req_valid,
  input  logic [N_REQ-1:0]           req_write,
  input  logic [N_REQ-1:0]           req_qsel,
  input  logic [N_REQ-1:0]           req_remote,
  input  logic [N_REQ*W-1:0]         req_wdata,
  output logic [N_REQ-1:0]           gnt,
  output logic [N_REQ-1:0]           rsp_valid,
  output logic [W-1:0]               rsp_data,
  output logic [$clog2(DEPTH+1)-1:0] free_level,
  output logic [$clog2(DEPTH+1)-1:0] post_level,
  output logic                       free_overflow,
  output logic                       post_overflow,
  output logic                       access_error
);
  localparam int CW = $clog2(DEPTH + 1);

  // granted request, selected
  logic         s_hit, s_wr, s_qsel, s_remote;
  logic [W-1:0] s_wdata;

  // named internal events (used by the checker)
  logic [1:0]   ev_push, ev_pop, ev_drop;
  logic         ev_bad, ev_mark;
  logic [W-1:0] rdata_next;

  logic [1:0]   q_full, q_empty;
  logic [W-1:0] q_head  [2];
  logic [CW-1:0] q_level [2];
  logic [1:0]   ovf_q;
  logic         err_q;

  mq_prio_arb #(.N(N_REQ)) u_arb (
    .en  (!init),
    .req (req_valid),
    .gnt (gnt)
  );

  always_comb begin
    s_hit    = 1'b0;
    s_wr     = 1'b0;
    s_qsel   = 1'b0;
    s_remote = 1'b0;
    s_wdata  = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (gnt[i]) begin
        s_hit    = 1'b1;
        s_wr     = req_write[i];
        s_qsel   = req_qsel[i];
        s_remote = req_remote[i];
        s_wdata  = req_wdata[i*W +: W];
      end
    end
  end

  mq_gate #(.W(W)) u_gate (
    .hit       (s_hit),
    .wr        (s_wr),
    .qsel      (s_qsel),
    .remote    (s_remote),
    .full      (q_full),
    .empty     (q_empty),
    .head_free (q_head[0]),
    .head_post (q_head[1]),
    .push      (ev_push),
    .pop       (ev_pop),
    .drop      (ev_drop),
    .bad       (ev_bad),
    .mark      (ev_mark),
    .rdata     (rdata_next)
  );

  for (genvar q = 0; q < 2; q++) begin : g_q
    mq_ring #(.W(W), .DEPTH(DEPTH)) u_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (init),
      .push  (ev_push[q]),
      .pop   (ev_pop[q]),
      .wdata (s_wdata),
      .head  (q_head[q]),
      .level (q_level[q]),
      .full  (q_full[q]),
      .empty (q_empty[q])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ovf_q[q] <= 1'b0;
      else if (init) ovf_q[q] <= 1'b0;
      else           ovf_q[q] <= ovf_q[q] | ev_drop[q];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_data  <= '0;
      err_q     <= 1'b0;
    end else begin
      rsp_valid <= gnt;
      rsp_data  <= rdata_next;
      err_q     <= init ? 1'b0 : (err_q | ev_bad);
    end
  end

  assign free_level    = q_level[0];
  assign post_level    = q_level[1];
  assign free_overflow = ovf_q[0];
  assign post_overflow = ovf_q[1];
  assign access_error  = err_q;

endmodule

// File: rtl/mq_pair_chk.sv
module mq_pair_chk #(
  parameter int N_REQ = 3,
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       init,
  input logic [N_REQ-1:0]           gnt,
  input logic [N_REQ-1:0]           rsp_valid,
  input logic [W-1:0]               rsp_data,
  input logic [$clog2(DEPTH+1)-1:0] free_level,
  input logic [$clog2(DEPTH+1)-1:0] post_level,
  input logic                       free_overflow,
  input logic                       post_overflow,
  input logic                       access_error,
  input logic [1:0]                 ev_drop,
  input logic                       ev_bad,
  input logic                       ev_mark
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R7

  AST_RSP_FOLLOWS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rsp_valid == $past(gnt))); // R8

  AST_EMPTY_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mark |=> (rsp_data == '1 && $stable(free_level) && $stable(post_level))); // R4

  AST_DROP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_drop[0] && !init) |=> ($stable(free_level) && free_overflow)); // R5

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (free_overflow && !init) |=> free_overflow); // R5

  AST_WRONG_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bad && !init) |=> (rsp_data == '0 && access_error &&
                           $stable(free_level) && $stable(post_level))); // R6

  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (free_level == '0 && post_level == '0 && !free_overflow &&
              !post_overflow && !access_error)); // R9

  AST_NO_GNT_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    init |-> (gnt == '0)); // R9

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !init |=> (free_level == $past(free_level) ||
               free_level == $past(free_level) + 1'b1 ||
               free_level == $past(free_level) - 1'b1)); // R7

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(free_level) <= DEPTH && 32'(post_level) <= DEPTH)); // R5

endmodule

bind mq_pair mq_pair_chk #(.N_REQ(N_REQ), .W(W), .DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .init          (init),
  .gnt           (gnt),
  .rsp_valid     (rsp_valid),
  .rsp_data      (rsp_data),
  .free_level    (free_level),
  .post_level    (post_level),
  .free_overflow (free_overflow),
  .post_overflow (post_overflow),
  .access_error  (access_error),
  .ev_drop       (ev_drop),
  .ev_bad        (ev_bad),
  .ev_mark       (ev_mark)
);

// File: tb/mq_pair_test.sv
`timescale 1ns/1ps
module mq_pair_test;
  localparam int N     = 3;
  localparam int W     = 32;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b0;
  logic [N-1:0]   req_valid = '0, req_write = '0, req_qsel = '0, req_remote = '0;
  logic [N*W-1:0] req_wdata = '0;
  logic [N-1:0]   gnt, rsp_valid;
  logic [W-1:0]   rsp_data;
  logic [CW-1:0]  free_level, post_level;
  logic           free_overflow, post_overflow, access_error;

  always #10 clk = ~clk;

  mq_pair #(.N_REQ(N), .W(W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .init(init),
    .req_valid(req_valid), .req_write(req_write), .req_qsel(req_qsel),
    .req_remote(req_remote), .req_wdata(req_wdata),
    .gnt(gnt), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .free_level(free_level), .post_level(post_level),
    .free_overflow(free_overflow), .post_overflow(post_overflow),
    .access_error(access_error)
  );

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] fq[$];
  logic [31:0] pq[$];
  bit m_ovf_f = 0, m_ovf_p = 0, m_err = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // side rule stated in R2/R3: free written locally, read remotely; post the reverse
  function automatic bit permitted(bit wr, bit sel, bit rem);
    if (sel == 1'b0) return wr ? !rem : rem;
    else             return wr ? rem : !rem;
  endfunction

  function automatic string tag_of(bit wr, bit sel, bit rem);
    int sz;
    sz = (sel == 1'b0) ? fq.size() : pq.size();
    if (!permitted(wr, sel, rem)) return "R6";
    if (wr && sz == DEPTH) return "R5";
    if (!wr && sz == 0) return "R4";
    return sel ? "R3" : "R2";
  endfunction

  task automatic model(bit wr, bit sel, bit rem, logic [31:0] d, output logic [31:0] r);
    r = 32'h0;
    if (!permitted(wr, sel, rem)) begin
      m_err = 1;
    end else if (wr) begin
      if (sel == 1'b0) begin
        if (fq.size() == DEPTH) m_ovf_f = 1; else fq.push_back(d);
      end else begin
        if (pq.size() == DEPTH) m_ovf_p = 1; else pq.push_back(d);
      end
    end else begin
      if (sel == 1'b0) r = (fq.size() == 0) ? 32'hFFFF_FFFF : fq.pop_front();
      else             r = (pq.size() == 0) ? 32'hFFFF_FFFF : pq.pop_front();
    end
  endtask

  task automatic check_state(string tag);
    chk({tag, " free_level"}, 32'(free_level), 32'(fq.size()));
    chk({tag, " post_level"}, 32'(post_level), 32'(pq.size()));
    chk({tag, " free_overflow"}, 32'(free_overflow), 32'(m_ovf_f));
    chk({tag, " post_overflow"}, 32'(post_overflow), 32'(m_ovf_p));
    chk({tag, " access_error"}, 32'(access_error), 32'(m_err));
  endtask

  // called at a negative edge; returns at the following negative edge
  task automatic cycle(logic [N-1:0] v, logic [N-1:0] wr, logic [N-1:0] sel,
                       logic [N-1:0] rem, logic [N*W-1:0] d);
    int win;
    logic [31:0] r;
    string t;
    req_valid = v; req_write = wr; req_qsel = sel; req_remote = rem; req_wdata = d;
    win = -1;
    for (int i = N - 1; i >= 0; i--) if (v[i]) win = i;
    #1;
    chk("R7 gnt lowest index", 32'(gnt), (win < 0) ? 32'h0 : (32'h1 << win));
    t = (win < 0) ? "R7" : tag_of(wr[win], sel[win], rem[win]);
    if (win >= 0) model(wr[win], sel[win], rem[win], d[win*W +: W], r);
    @(posedge clk);
    @(negedge clk);
    chk("R8 rsp_valid", 32'(rsp_valid), (win < 0) ? 32'h0 : (32'h1 << win));
    if (win >= 0) chk({t, " rsp_data"}, rsp_data, r);
    check_state(t);
    req_valid = '0;
  endtask

  task automatic single(int id, bit wr, bit sel, bit rem, logic [31:0] d);
    logic [N*W-1:0] dd;
    dd = '0;
    dd[id*W +: W] = d;
    cycle(N'(1) << id, wr ? (N'(1) << id) : '0, sel ? (N'(1) << id) : '0,
          rem ? (N'(1) << id) : '0, dd);
  endtask

  task automatic do_init();
    init = 1'b1;
    req_valid = '1; req_write = '0; req_qsel = '0; req_remote = '1;
    #1;
    chk("R9 no grant during init", 32'(gnt), 32'h0);
    @(posedge clk);
    @(negedge clk);
    init = 1'b0;
    req_valid = '0;
    fq.delete(); pq.delete();
    m_ovf_f = 0; m_ovf_p = 0; m_err = 0;
    check_state("R9");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", 32'(rsp_valid), 32'h0);
    check_state("R1");

    // R4 empty reads on both queues
    single(1, 0, 0, 1, 0);
    single(0, 0, 1, 0, 0);

    // R2 fill free queue locally, then R5 overflow
    for (int k = 0; k < DEPTH; k++) single(0, 1, 0, 0, 32'h1000 + 32'(k));
    single(2, 1, 0, 0, 32'hDEAD_0001);
    single(0, 1, 0, 0, 32'hDEAD_0002);

    // R2 remote claims, R3 remote posts, local drains
    for (int k = 0; k < 3; k++) single(1, 0, 0, 1, 0);
    for (int k = 0; k < 3; k++) single(2, 1, 1, 1, 32'h2000 + 32'(k));
    for (int k = 0; k < 4; k++) single(0, 0, 1, 0, 0);

    // R6 wrong side accesses
    single(0, 0, 0, 0, 0);
    single(1, 1, 0, 1, 32'hBAD0_0000);
    single(2, 1, 1, 0, 32'hBAD0_0001);
    single(1, 0, 1, 1, 0);

    // R7 contention
    cycle(3'b111, 3'b000, 3'b000, 3'b111, {32'h3, 32'h2, 32'h1});
    cycle(3'b110, 3'b110, 3'b110, 3'b110, {32'h33, 32'h22, 32'h11});
    cycle(3'b100, 3'b000, 3'b100, 3'b000, '0);

    // R9 initialize
    do_init();

    // random traffic, wrapping pointers many times
    for (int it = 0; it < 1500; it++) begin
      logic [N*W-1:0] d;
      logic [N-1:0] v;
      for (int j = 0; j < N; j++) d[j*W +: W] = $urandom();
      v = N'($urandom());
      if (($urandom() % 4) == 0) v = N'(1) << ($urandom() % N);
      cycle(v, N'($urandom()), N'($urandom()), N'($urandom()), d);
      if (it == 900) do_init();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule